// File: doc/BRIEF.md
# Command Queue Thread Controller

This block is one execution thread of a command-queue engine. Software loads a start address and an end address through a 32-bit register port, then sets the enable bit. The thread fetches 64-bit instructions, one at a time, over a simple read request/response port. It executes them until its program counter equals the end address. At that point it raises a done status bit and clears its own enable bit.

Only the jump instruction is decoded. Any other legal word is a no-op that advances the program counter by 8. A word with bit 63 set, other than a jump, is illegal. It raises an error status bit and halts the thread. A read response flagged as an error does the same on a separate status bit.

Software chains buffers while the thread runs. It pauses the thread, moves the end address and rewrites the program counter. Any write of the program counter throws away both the held instruction and any fetch still in flight. A timed warm reset returns the thread to a clean idle state. An interrupt output reports enabled status bits.

Top module: `cmdq_thread_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is 0 and no fetch request is issued.
- R2: Fetching and done.
  - While enable (offset 0x04, bit 0) is 1, the thread fetches the 8-byte word at the program counter (offset 0x20), with at most one fetch outstanding.
  - A non-jump word whose bit 63 is 0 advances the program counter by 8.
  - When an executed instruction leaves the program counter equal to the end address (offset 0x24), interrupt status (offset 0x10) bit 0 is set and enable clears to 0.
- R3: A word whose upper 32 bits are 0x10000001 loads the program counter with its lower 32 bits. Any other upper value with bit 63 clear, for example 0x10000002, is a plain step.
- R4: A non-jump word with bit 63 set sets interrupt status bit 1. The program counter then holds and no further fetch is issued, until the program counter is written or a warm reset occurs. Enable stays 1.
- R5: A fetch response with `mem_rerr_i` high sets interrupt status bit 4 and halts the thread the same way as R4.
- R6: Interrupt status and the interrupt output.
  - Writing interrupt status clears each bit written as 0 and keeps each bit written as 1.
  - `irq_o` is high exactly when some status bit is set whose bit in interrupt enable (offset 0x14) is also set.
- R7: Suspend.
  - While suspend (offset 0x08, bit 0) is 1, no instruction executes. One instruction may still be prefetched.
  - Status (offset 0x0C) bit 1 reads 1 once suspend is set and no fetch is outstanding.
  - Writing suspend to 0 resumes execution.
- R8: Writing the program counter, even with its present value, does three things:
  - it discards the held instruction and any in-flight response;
  - it restarts fetching at the written address;
  - it clears a halt.
- R9: A new end address written while the thread is paused takes effect on resume. The thread then runs on to the new end address.
- R10: Warm reset.
  - Writing 1 to bit 0 of offset 0x00 starts a warm reset. That bit reads 1 for at least `RST_CYCLES` (4) cycles and until no fetch is outstanding, then reads 0.
  - The reset clears enable, suspend, interrupt status, the held instruction and any halt.
  - The program counter, end address, priority and interrupt enable are unchanged.
- R11: Writing 0 to enable stops execution. The program counter then holds and no further fetch is issued.
- R12: Bit 31 of offset 0x30 mirrors `evt_wait_i`. Offset 0x40 stores `PRIO_W` (3) bits, and the higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | Register write when 1, read when 0 |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on `reg_addr_i` |
| mem_req_o | output | 1 | One-cycle fetch request |
| mem_addr_o | output | 32 | Fetch byte address |
| mem_rvalid_i | input | 1 | Fetch response valid |
| mem_rerr_i | input | 1 | Fetch response error |
| mem_rdata_i | input | 64 | Fetched instruction word |
| evt_wait_i | input | 1 | Thread is blocked on an event |
| irq_o | output | 1 | Interrupt request |

## Verification
Straight runs of no-op buffers are swept over lengths 1 to 8. The final program counter and the fetch count show whether the end compare is off by one instruction. Jumps are swept over their position, and a near-jump word shows that only the exact upper word is decoded.

The flush case pauses the thread with a stale word already prefetched, changes memory and rewrites the same address. The fetch count then tells a refetch apart from execution of the stale word. Illegal, bus-error, disable and pause cases check that the program counter and the fetch count freeze. Warm reset checks which registers it clears and which it keeps.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int REG_DW     = 32;
  localparam int PC_W       = 32;
  localparam int INSN_W     = 64;
  localparam int INSN_BYTES = 8;
  localparam int IRQ_W      = 5;

  localparam logic [7:0] OFS_RST  = 8'h00;
  localparam logic [7:0] OFS_EN   = 8'h04;
  localparam logic [7:0] OFS_SUSP = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_ISTS = 8'h10;
  localparam logic [7:0] OFS_IEN  = 8'h14;
  localparam logic [7:0] OFS_PC   = 8'h20;
  localparam logic [7:0] OFS_END  = 8'h24;
  localparam logic [7:0] OFS_WAIT = 8'h30;
  localparam logic [7:0] OFS_PRIO = 8'h40;

  localparam logic [31:0] JUMP_HI = 32'h1000_0001;

  localparam int IRQ_DONE = 0;
  localparam int IRQ_ILL  = 1;
  localparam int IRQ_BUS  = 4;

  typedef enum logic [1:0] {OP_STEP, OP_JUMP, OP_ILLEGAL} op_e;

  function automatic op_e insn_decode(input logic [INSN_W-1:0] insn);
    if (insn[INSN_W-1:PC_W] == JUMP_HI) return OP_JUMP;
    else if (insn[INSN_W-1])            return OP_ILLEGAL;
    else                                return OP_STEP;
  endfunction
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int REG_AW     = 8,
  parameter int PRIO_W     = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              pend_i,
  input  logic              done_i,
  input  logic              evt_wait_i,
  input  logic [IRQ_W-1:0]  irq_sts_i,
  input  logic [IRQ_W-1:0]  irq_en_i,
  output logic              en_o,
  output logic              susp_o,
  output logic [PC_W-1:0]   end_o,
  output logic              pc_wr_o,
  output logic              ists_wr_o,
  output logic              ien_wr_o,
  output logic              rst_start_o,
  output logic              rst_busy_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic              wr;
  logic              en_q, susp_q, busy_q;
  logic [PC_W-1:0]   end_q;
  logic [PRIO_W-1:0] prio_q;
  logic [CNT_W-1:0]  cnt_q;

  assign wr          = req_i & we_i;
  assign rst_start_o = wr && (addr_i == REG_AW'(OFS_RST)) && wdata_i[0];
  assign pc_wr_o     = wr && (addr_i == REG_AW'(OFS_PC));
  assign ists_wr_o   = wr && (addr_i == REG_AW'(OFS_ISTS));
  assign ien_wr_o    = wr && (addr_i == REG_AW'(OFS_IEN));

  // warm-reset timer: minimum length, then wait for the fetch port to drain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (rst_start_o) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(RST_CYCLES);
    end else if (busy_q) begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      else if (!pend_i) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      susp_q <= 1'b0;
      end_q  <= '0;
      prio_q <= '0;
    end else begin
      if (rst_start_o) en_q <= 1'b0;
      else if (wr && addr_i == REG_AW'(OFS_EN)) en_q <= wdata_i[0];
      else if (done_i) en_q <= 1'b0;

      if (rst_start_o) susp_q <= 1'b0;
      else if (wr && addr_i == REG_AW'(OFS_SUSP)) susp_q <= wdata_i[0];

      if (wr && addr_i == REG_AW'(OFS_END))  end_q  <= wdata_i;
      if (wr && addr_i == REG_AW'(OFS_PRIO)) prio_q <= wdata_i[PRIO_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_AW'(OFS_RST):  rdata_o = REG_DW'(busy_q);
      REG_AW'(OFS_EN):   rdata_o = REG_DW'(en_q);
      REG_AW'(OFS_SUSP): rdata_o = REG_DW'(susp_q);
      REG_AW'(OFS_STAT): rdata_o = REG_DW'({susp_q & ~pend_i, 1'b0});
      REG_AW'(OFS_ISTS): rdata_o = REG_DW'(irq_sts_i);
      REG_AW'(OFS_IEN):  rdata_o = REG_DW'(irq_en_i);
      REG_AW'(OFS_PC):   rdata_o = pc_i;
      REG_AW'(OFS_END):  rdata_o = end_q;
      REG_AW'(OFS_WAIT): rdata_o = {evt_wait_i, {(REG_DW-1){1'b0}}};
      REG_AW'(OFS_PRIO): rdata_o = REG_DW'(prio_q);
      default:           rdata_o = '0;
    endcase
  end

  assign en_o       = en_q;
  assign susp_o     = susp_q;
  assign end_o      = end_q;
  assign rst_busy_o = busy_q;
endmodule

// File: rtl/cmdq_irq.sv
module cmdq_irq
  import cmdq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rst_start_i,
  input  logic             sts_wr_i,
  input  logic             en_wr_i,
  input  logic [IRQ_W-1:0] wdata_i,
  input  logic [IRQ_W-1:0] set_i,
  output logic [IRQ_W-1:0] sts_o,
  output logic [IRQ_W-1:0] en_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] sts_q, en_q;

  for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sts_q[i] <= 1'b0;
        en_q[i]  <= 1'b0;
      end else begin
        if (rst_start_i) sts_q[i] <= 1'b0;
        else sts_q[i] <= (sts_q[i] & (~sts_wr_i | wdata_i[i])) | set_i[i];
        if (en_wr_i) en_q[i] <= wdata_i[i];
      end
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign irq_o = |(sts_q & en_q);
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              susp_i,
  input  logic              pc_wr_i,
  input  logic [PC_W-1:0]   pc_wdata_i,
  input  logic              rst_start_i,
  input  logic              rst_busy_i,
  input  logic [PC_W-1:0]   end_i,
  output logic              mem_req_o,
  output logic [PC_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic              mem_rerr_i,
  input  logic [INSN_W-1:0] mem_rdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              pend_o,
  output logic              done_o,
  output logic [IRQ_W-1:0]  irq_set_o
);
  logic [PC_W-1:0]   pc_q, fetch_addr_q, buf_addr_q, next_pc;
  logic [INSN_W-1:0] buf_data_q;
  logic              buf_v_q, pend_q, drop_q, halted_q;
  logic              flush, at_end, buf_hit, run_ok, issue, exec, rsp_keep;
  op_e               op;

  assign flush    = pc_wr_i | rst_start_i;
  assign at_end   = (pc_q == end_i);
  assign buf_hit  = buf_v_q && (buf_addr_q == pc_q);
  assign run_ok   = en_i & ~halted_q & ~rst_busy_i & ~flush & ~at_end;
  // prefetch continues while suspended; execution does not
  assign issue    = run_ok & ~pend_q & ~buf_hit;
  assign exec     = run_ok & ~susp_i & buf_hit;
  assign rsp_keep = mem_rvalid_i & ~drop_q & ~flush;

  always_comb begin
    op = insn_decode(buf_data_q);
    case (op)
      OP_JUMP: next_pc = buf_data_q[PC_W-1:0];
      OP_STEP: next_pc = pc_q + PC_W'(INSN_BYTES);
      default: next_pc = pc_q;
    endcase
  end

  assign done_o = exec && (op != OP_ILLEGAL) && (next_pc == end_i);

  always_comb begin
    irq_set_o           = '0;
    irq_set_o[IRQ_DONE] = done_o;
    irq_set_o[IRQ_ILL]  = exec && (op == OP_ILLEGAL);
    irq_set_o[IRQ_BUS]  = rsp_keep & mem_rerr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q         <= '0;
      fetch_addr_q <= '0;
      pend_q       <= 1'b0;
      drop_q       <= 1'b0;
      halted_q     <= 1'b0;
      buf_v_q      <= 1'b0;
      buf_addr_q   <= '0;
      buf_data_q   <= '0;
    end else begin
      if (pc_wr_i)   pc_q <= pc_wdata_i;
      else if (exec) pc_q <= next_pc;

      if (issue) begin
        pend_q       <= 1'b1;
        drop_q       <= 1'b0;
        fetch_addr_q <= pc_q;
      end else if (mem_rvalid_i) begin
        pend_q <= 1'b0;
        drop_q <= 1'b0;
      end else if (pend_q && flush) begin
        drop_q <= 1'b1;
      end

      if (flush) buf_v_q <= 1'b0;
      else if (rsp_keep && !mem_rerr_i) begin
        buf_v_q    <= 1'b1;
        buf_addr_q <= fetch_addr_q;
        buf_data_q <= mem_rdata_i;
      end else if (exec) buf_v_q <= 1'b0;

      if (flush) halted_q <= 1'b0;
      else if ((exec && op == OP_ILLEGAL) || (rsp_keep && mem_rerr_i)) halted_q <= 1'b1;
    end
  end

  assign mem_req_o  = issue;
  assign mem_addr_o = pc_q;
  assign pc_o       = pc_q;
  assign pend_o     = pend_q;
endmodule

// File: rtl/cmdq_thread_ctrl.sv
module cmdq_thread_ctrl
  import cmdq_pkg::*;
#(
  parameter int REG_AW     = 8,
  parameter int PRIO_W     = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              mem_req_o,
  output logic [PC_W-1:0]   mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic              mem_rerr_i,
  input  logic [INSN_W-1:0] mem_rdata_i,
  input  logic              evt_wait_i,
  output logic              irq_o
);
  logic             en, susp, pc_wr, ists_wr, ien_wr, rst_start, rst_busy, pend, done;
  logic [PC_W-1:0]  pc, end_addr;
  logic [IRQ_W-1:0] irq_sts, irq_en, irq_set;

  cmdq_regs #(
    .REG_AW    (REG_AW),
    .PRIO_W    (PRIO_W),
    .RST_CYCLES(RST_CYCLES)
  ) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (reg_req_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .pc_i       (pc),
    .pend_i     (pend),
    .done_i     (done),
    .evt_wait_i (evt_wait_i),
    .irq_sts_i  (irq_sts),
    .irq_en_i   (irq_en),
    .en_o       (en),
    .susp_o     (susp),
    .end_o      (end_addr),
    .pc_wr_o    (pc_wr),
    .ists_wr_o  (ists_wr),
    .ien_wr_o   (ien_wr),
    .rst_start_o(rst_start),
    .rst_busy_o (rst_busy)
  );

  cmdq_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .susp_i      (susp),
    .pc_wr_i     (pc_wr),
    .pc_wdata_i  (reg_wdata_i),
    .rst_start_i (rst_start),
    .rst_busy_i  (rst_busy),
    .end_i       (end_addr),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rerr_i  (mem_rerr_i),
    .mem_rdata_i (mem_rdata_i),
    .pc_o        (pc),
    .pend_o      (pend),
    .done_o      (done),
    .irq_set_o   (irq_set)
  );

  cmdq_irq i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_start_i(rst_start),
    .sts_wr_i   (ists_wr),
    .en_wr_i    (ien_wr),
    .wdata_i    (reg_wdata_i[IRQ_W-1:0]),
    .set_i      (irq_set),
    .sts_o      (irq_sts),
    .en_o       (irq_en),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/cmdq_thread_chk.sv
module cmdq_thread_chk
  import cmdq_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic              reg_req,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [REG_DW-1:0] reg_wdata,
  input logic [PC_W-1:0]   pc,
  input logic              pc_wr,
  input logic              susp,
  input logic              en,
  input logic              done,
  input logic              rst_start,
  input logic [IRQ_W-1:0]  irq_sts
);
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         out_q <= 1'b0;
    else if (mem_req)    out_q <= 1'b1;
    else if (mem_rvalid) out_q <= 1'b0;
  end

  assert_single_fetch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req |-> !out_q);

  assert_done_clears_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && !(reg_req && reg_we && reg_addr == REG_AW'(OFS_EN))) |=> !en);

  assert_suspend_holds_pc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp && !pc_wr) |=> $stable(pc));

  assert_pc_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr |=> (pc == $past(reg_wdata)));

  assert_reset_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_start |=> (irq_sts == '0) && !susp);
endmodule

bind cmdq_thread_ctrl cmdq_thread_chk #(.REG_AW(REG_AW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mem_req   (mem_req_o),
  .mem_rvalid(mem_rvalid_i),
  .reg_req   (reg_req_i),
  .reg_we    (reg_we_i),
  .reg_addr  (reg_addr_i),
  .reg_wdata (reg_wdata_i),
  .pc        (pc),
  .pc_wr     (pc_wr),
  .susp      (susp),
  .en        (en),
  .done      (done),
  .rst_start (rst_start),
  .irq_sts   (irq_sts)
);

// File: tb/test_cmdq_thread_ctrl.sv
module test_cmdq_thread_ctrl;
  localparam logic [7:0] A_RST = 8'h00, A_EN = 8'h04, A_SUSP = 8'h08, A_STAT = 8'h0C;
  localparam logic [7:0] A_ISTS = 8'h10, A_IEN = 8'h14, A_PC = 8'h20, A_END = 8'h24;
  localparam logic [7:0] A_WAIT = 8'h30, A_PRIO = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_rvalid, mem_rerr, evt_wait = 1'b0, irq;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata;
  logic [63:0] mem [32];
  logic        s1_v = 1'b0, s2_v = 1'b0;
  logic [31:0] s1_a = '0, s2_a = '0;
  int          nfetch = 0;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cmdq_thread_ctrl i_cmdq_thread_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(reg_req), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rerr_i(mem_rerr), .mem_rdata_i(mem_rdata),
    .evt_wait_i(evt_wait), .irq_o(irq)
  );

  // two-cycle memory model; addresses at or above 0x100 answer with an error
  always @(posedge clk) begin
    s1_v <= mem_req; s1_a <= mem_addr;
    s2_v <= s1_v;    s2_a <= s1_a;
    if (mem_req) nfetch <= nfetch + 1;
  end
  assign mem_rvalid = s2_v;
  assign mem_rdata  = mem[s2_a[7:3]];
  assign mem_rerr   = |s2_a[31:8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(A_EN, v);
      if (v == 0) break;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v, p;
    int f0;
    for (int i = 0; i < 32; i++) mem[i] = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(A_EN, v);   chk("R1 enable", v, 0);
    rd(A_SUSP, v); chk("R1 suspend", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);
    rd(A_ISTS, v); chk("R1 irq status", v, 0);
    rd(A_IEN, v);  chk("R1 irq enable", v, 0);
    rd(A_PC, v);   chk("R1 pc", v, 0);
    rd(A_END, v);  chk("R1 end", v, 0);
    rd(A_RST, v);  chk("R1 warm reset", v, 0);
    chk("R1 irq_o", 32'(irq), 0);
    chk("R1 no fetch", nfetch, 0);

    wr(A_IEN, 32'h13);

    // R2 straight runs of 1..8 no-ops
    for (int n = 1; n <= 8; n++) begin
      wr(A_ISTS, 0);
      f0 = nfetch;
      wr(A_END, 32'(n * 8));
      wr(A_PC, 0);
      wr(A_EN, 1);
      wait_done();
      rd(A_EN, v);   chk("R2 enable cleared", v, 0);
      rd(A_PC, v);   chk("R2 pc at end", v, 32'(n * 8));
      chk("R2 fetch count", nfetch - f0, n);
      rd(A_ISTS, v); chk("R2 done bit", v, 32'h1);
      chk("R2 irq_o", 32'(irq), 1);
    end

    // R3 jump at position k to 0x80, end 0x98
    for (int k = 0; k < 4; k++) begin
      mem[k] = {32'h1000_0001, 32'h80};
      wr(A_ISTS, 0);
      f0 = nfetch;
      wr(A_END, 32'h98);
      wr(A_PC, 0);
      wr(A_EN, 1);
      wait_done();
      rd(A_PC, v); chk("R3 pc after jump", v, 32'h98);
      chk("R3 fetch count", nfetch - f0, k + 4);
      mem[k] = '0;
    end
    // R3 near-jump upper word is a plain step
    mem[0] = {32'h1000_0002, 32'h80};
    f0 = nfetch;
    wr(A_END, 32'h10); wr(A_PC, 0); wr(A_EN, 1);
    wait_done();
    rd(A_PC, v); chk("R3 near-jump steps", v, 32'h10);
    chk("R3 near-jump fetches", nfetch - f0, 2);
    mem[0] = '0;

    // R4 illegal opcode at index 2
    mem[2] = {32'h8000_0000, 32'h0};
    wr(A_ISTS, 0);
    f0 = nfetch;
    wr(A_END, 32'h40); wr(A_PC, 0); wr(A_EN, 1);
    idle(60);
    rd(A_PC, v);   chk("R4 pc holds", v, 32'h10);
    rd(A_ISTS, v); chk("R4 error bit", v, 32'h2);
    rd(A_EN, v);   chk("R4 enable stays", v, 1);
    chk("R4 fetch count", nfetch - f0, 3);
    chk("R4 irq_o", 32'(irq), 1);
    f0 = nfetch;
    idle(20);
    chk("R4 no further fetch", nfetch - f0, 0);
    // R8 pc write clears halt
    wr(A_PC, 32'h18);
    wait_done();
    rd(A_PC, v);   chk("R8 resume after halt", v, 32'h40);
    rd(A_ISTS, v); chk("R8 status after resume", v, 32'h3);
    mem[2] = '0;

    // R6 write-0-to-clear and enable gating
    wr(A_ISTS, 32'h12);
    rd(A_ISTS, v); chk("R6 partial clear", v, 32'h2);
    wr(A_IEN, 32'h01);
    idle(1); chk("R6 irq masked", 32'(irq), 0);
    wr(A_IEN, 32'h13);
    idle(1); chk("R6 irq unmasked", 32'(irq), 1);
    wr(A_ISTS, 0);
    rd(A_ISTS, v); chk("R6 full clear", v, 0);
    chk("R6 irq low", 32'(irq), 0);

    // R5 fetch bus error
    f0 = nfetch;
    wr(A_END, 32'h120); wr(A_PC, 32'h100); wr(A_EN, 1);
    idle(20);
    rd(A_ISTS, v); chk("R5 bus error bit", v, 32'h10);
    rd(A_PC, v);   chk("R5 pc holds", v, 32'h100);
    chk("R5 single fetch", nfetch - f0, 1);

    // R10 warm reset
    wr(A_SUSP, 1);
    wr(A_PRIO, 5);
    wr(A_RST, 1);
    rd(A_RST, v);  chk("R10 busy", v, 1);
    idle(6);
    rd(A_RST, v);  chk("R10 finished", v, 0);
    rd(A_ISTS, v); chk("R10 status cleared", v, 0);
    rd(A_SUSP, v); chk("R10 suspend cleared", v, 0);
    rd(A_EN, v);   chk("R10 enable cleared", v, 0);
    rd(A_PC, v);   chk("R10 pc kept", v, 32'h100);
    rd(A_END, v);  chk("R10 end kept", v, 32'h120);
    rd(A_PRIO, v); chk("R10 prio kept", v, 5);
    rd(A_IEN, v);  chk("R10 irq enable kept", v, 32'h13);

    // R7 suspend with prefetch, R8 flush of stale prefetch
    wr(A_END, 32'h48); wr(A_PC, 0); wr(A_SUSP, 1);
    f0 = nfetch;
    wr(A_EN, 1);
    idle(20);
    rd(A_STAT, v); chk("R7 paused flag", v, 32'h2);
    rd(A_PC, v);   chk("R7 pc held", v, 0);
    chk("R7 one prefetch", nfetch - f0, 1);
    mem[0] = {32'h1000_0001, 32'h40};
    wr(A_PC, 0);
    idle(20);
    rd(A_STAT, v); chk("R7 paused after refetch", v, 32'h2);
    chk("R8 refetch after pc write", nfetch - f0, 2);
    wr(A_SUSP, 0);
    wait_done();
    rd(A_PC, v); chk("R7 resumed to end", v, 32'h48);
    chk("R8 new word executed", nfetch - f0, 3);
    mem[0] = '0;

    // R9 end address moved while paused
    wr(A_ISTS, 0);
    wr(A_END, 32'hF8); wr(A_PC, 0); wr(A_EN, 1);
    idle(6);
    wr(A_SUSP, 1);
    idle(20);
    rd(A_STAT, v); chk("R9 paused", v, 32'h2);
    rd(A_PC, p);   chk("R9 paused early", 32'(p < 32'h60), 1);
    wr(A_END, 32'h60);
    wr(A_SUSP, 0);
    wait_done();
    rd(A_PC, v);   chk("R9 new end reached", v, 32'h60);
    rd(A_ISTS, v); chk("R9 done bit", v, 32'h1);

    // R11 disable mid-run
    wr(A_ISTS, 0);
    wr(A_END, 32'hF8); wr(A_PC, 0); wr(A_EN, 1);
    idle(8);
    wr(A_EN, 0);
    idle(6);
    rd(A_PC, p);
    f0 = nfetch;
    idle(30);
    rd(A_PC, v);   chk("R11 pc holds", v, p);
    chk("R11 no fetch", nfetch - f0, 0);
    rd(A_ISTS, v); chk("R11 no done", v, 0);

    // R12 wait flag and priority width
    rd(A_WAIT, v); chk("R12 wait low", v, 0);
    evt_wait = 1'b1;
    rd(A_WAIT, v); chk("R12 wait high", v, 32'h8000_0000);
    wr(A_PRIO, 32'hFFFF_FFFF);
    rd(A_PRIO, v); chk("R12 prio width", v, 7);

    summary();
    $finish;
  end
endmodule